// File: doc/BRIEF.md
# Programmable interrupt priority resolver

This block is the core of one eight-channel interrupt controller. Request lines are synchronized and edge-captured into a pending-request register. A mask register gates them. An in-service register records the channels the processor is currently handling. Combinational resolution picks the best eligible channel and raises `intr`. An acknowledge pulse moves that channel into service and presents an eight-bit vector. The vector is a five-bit base, loaded by the initialize command, followed by the channel number.

Priority is a ring of eight channels with a movable top. After reset or initialize, channel 0 is on top and channel 7 is at the bottom. A rotate command names a new top channel. In automatic-rotation mode, each channel that leaves service becomes the lowest. In-service channels can be released by a specific end-of-interrupt, by a non-specific one, or automatically two cycles after the acknowledge. In poll mode `intr` stays low, and software chooses a channel from the request register. Bus decoding and cascading are outside the block; commands arrive as one-cycle strobes with decoded fields.

The acknowledge sequencer has three states. `S_IDLE` waits; an `ack_pulse` there moves to `S_GRANT` (transition *take*). `S_GRANT` presents the vector for one cycle, then returns to `S_IDLE` (transition *done*) or, with auto-release set, goes to `S_AEOI` (transition *auto*). `S_AEOI` releases one in-service bit and returns to `S_IDLE` (transition *release*). An `ack_pulse` outside `S_IDLE` is ignored.

Top module: `prio_irq_core`

## Requirements
- R1: A rising edge on `irq_in[c]` sets `irr[c]` within four clock edges. A level held high sets it only once. `irr[c]` clears only when channel c is granted.
- R2: A `cmd_mask` strobe loads `imr` from `mask_val`. A channel with its `imr` bit at 1 is never selected and cannot raise `intr`.
- R3: `intr` is high exactly when an unmasked pending channel exists whose priority is strictly above every set `isr` bit, and poll mode is off.
- R4: After reset or `cmd_init`, priority is fixed: channel 0 highest, then 1, 2 and so on, with channel 7 lowest.
- R5: `ack_pulse` in `S_IDLE` with an eligible winner sets that channel's `isr` bit and clears its `irr` bit. In the next cycle `vec_valid` is 1 and `vec` = {base, channel[2:0]}.
- R6: `ack_pulse` with no eligible winner returns channel field 7 and leaves `isr` and `irr` unchanged.
- R7: `cmd_rot` with `rot_top`=t makes the priority order t, t+1, …, 7, 0, …, t-1.
- R8: With automatic rotation on, a channel whose `isr` bit is released by any end-of-interrupt becomes the lowest priority.
- R9: `cmd_eoi` with `eoi_specific`=1 clears `isr[eoi_chan]`. With `eoi_specific`=0, it clears the highest-priority set `isr` bit among unmasked channels.
- R10: With auto-release set by `cmd_init` (`init_aeoi`=1), the highest-priority unmasked `isr` bit is cleared on the second clock edge after the acknowledge edge.
- R11: With `mode_poll`=1 loaded by `cmd_mode`, `intr` stays 0 while requests keep being captured and acknowledges keep granting.
- R12: A captured edge on channel c in the same cycle that channel c is granted leaves `irr[c]` set.
- R13: `cmd_init` clears `imr` and `isr`, resets the top to channel 0, turns off poll and automatic rotation, and loads the vector base and auto-release flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 8 | Asynchronous request lines |
| ack_pulse | input | 1 | One-cycle acknowledge |
| cmd_init | input | 1 | Initialize strobe |
| init_vbase | input | 5 | Vector base loaded by initialize |
| init_aeoi | input | 1 | Auto-release flag loaded by initialize |
| cmd_mask | input | 1 | Mask load strobe |
| mask_val | input | 8 | New mask, 1 = masked |
| cmd_eoi | input | 1 | End-of-interrupt strobe |
| eoi_specific | input | 1 | 1 = release `eoi_chan`, 0 = release highest |
| eoi_chan | input | 3 | Channel for a specific release |
| cmd_rot | input | 1 | Set-top-priority strobe |
| rot_top | input | 3 | Channel that becomes highest |
| cmd_mode | input | 1 | Mode load strobe |
| mode_poll | input | 1 | Poll mode enable |
| mode_autorot | input | 1 | Automatic rotation enable |
| intr | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Vector valid, the cycle after an accepted acknowledge |
| vec | output | 8 | Vector {base, channel} |
| irr | output | 8 | Pending-request register |
| isr | output | 8 | In-service register |
| imr | output | 8 | Mask register |

## Verification
The request capture and the grant can both write the same `irr` bit in one cycle: the grant clears it while a fresh edge sets it. The bench provokes this by raising the line of the only pending channel exactly two edges before the acknowledge edge, so the synchronized edge lands on the grant edge. It then requires the channel's `isr` bit set and its `irr` bit still set. Random traffic also mixes end-of-interrupt releases with auto-release and rotation, and compares every register and `intr` against a bench model after each operation.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_GRANT = 2'd1,
        S_AEOI  = 2'd2
    } ack_state_t;
endpackage

// File: rtl/irq_req_capture.sv
module irq_req_capture #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] req_in,
    input  logic [NCH-1:0] clr,
    output logic [NCH-1:0] irr
);
    logic [NCH-1:0] sync1, sync2, prev, rise;

    assign rise = sync2 & ~prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1 <= '0;
            sync2 <= '0;
            prev  <= '0;
            irr   <= '0;
        end else begin
            sync1 <= req_in;
            sync2 <= sync1;
            prev  <= sync2;
            // a new edge wins over a grant clear in the same cycle
            irr   <= (irr & ~clr) | rise;
        end
    end

    // R1
    irr_only_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((irr & ~$past(irr) & ~$past(rise)) == '0));
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int NCH = 8,
    localparam int CW = $clog2(NCH)
) (
    input  logic [NCH-1:0] bits,
    input  logic [CW-1:0]  top,
    output logic           found,
    output logic [CW-1:0]  chan,
    output logic [CW-1:0]  rank
);
    // scan from the bottom of the ring so the entry nearest the top wins
    always_comb begin
        found = 1'b0;
        chan  = '0;
        rank  = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (bits[top + CW'(i)]) begin
                found = 1'b1;
                chan  = top + CW'(i);
                rank  = CW'(i);
            end
        end
    end
endmodule

// File: rtl/prio_irq_core.sv
module prio_irq_core
    import irq_pkg::*;
#(
    parameter int NCH = 8,
    parameter int VW  = 8,
    localparam int CW = $clog2(NCH),
    localparam int BW = VW - CW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] irq_in,
    input  logic           ack_pulse,
    input  logic           cmd_init,
    input  logic [BW-1:0]  init_vbase,
    input  logic           init_aeoi,
    input  logic           cmd_mask,
    input  logic [NCH-1:0] mask_val,
    input  logic           cmd_eoi,
    input  logic           eoi_specific,
    input  logic [CW-1:0]  eoi_chan,
    input  logic           cmd_rot,
    input  logic [CW-1:0]  rot_top,
    input  logic           cmd_mode,
    input  logic           mode_poll,
    input  logic           mode_autorot,
    output logic           intr,
    output logic           vec_valid,
    output logic [VW-1:0]  vec,
    output logic [NCH-1:0] irr,
    output logic [NCH-1:0] isr,
    output logic [NCH-1:0] imr
);
    ack_state_t     state, state_n;
    logic [CW-1:0]  top_q, vec_chan;
    logic [BW-1:0]  vbase;
    logic           poll_en, autorot_en, aeoi_en;

    logic           req_found, isr_found, isu_found;
    logic [CW-1:0]  req_chan, req_rank, isr_chan, isr_rank, isu_chan, isu_rank;
    logic           elig, take;
    logic [NCH-1:0] grant_1h, eoi_clr, aeoi_clr;
    logic           eoi_hit, aeoi_hit;
    logic [CW-1:0]  eoi_ch;

    irq_req_capture #(.NCH(NCH)) u_cap (
        .clk(clk), .rst_n(rst_n), .req_in(irq_in), .clr(grant_1h), .irr(irr)
    );

    irq_prio_pick #(.NCH(NCH)) u_pick_req (
        .bits(irr & ~imr), .top(top_q),
        .found(req_found), .chan(req_chan), .rank(req_rank)
    );

    irq_prio_pick #(.NCH(NCH)) u_pick_isr (
        .bits(isr), .top(top_q),
        .found(isr_found), .chan(isr_chan), .rank(isr_rank)
    );

    irq_prio_pick #(.NCH(NCH)) u_pick_isu (
        .bits(isr & ~imr), .top(top_q),
        .found(isu_found), .chan(isu_chan), .rank(isu_rank)
    );

    // eligible: a pending winner ranked strictly above every in-service bit
    assign elig     = req_found && !(isr_found && (isr_rank <= req_rank));
    assign take     = (state == S_IDLE) && ack_pulse;
    assign grant_1h = (take && elig) ? (NCH'(1) << req_chan) : '0;

    always_comb begin
        eoi_ch  = eoi_specific ? eoi_chan : isu_chan;
        eoi_hit = cmd_eoi && (eoi_specific ? isr[eoi_chan] : isu_found);
        eoi_clr = eoi_hit ? (NCH'(1) << eoi_ch) : '0;
        aeoi_hit = (state == S_AEOI) && isu_found;
        aeoi_clr = aeoi_hit ? (NCH'(1) << isu_chan) : '0;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE:  if (ack_pulse) state_n = S_GRANT;
            S_GRANT: state_n = aeoi_en ? S_AEOI : S_IDLE;
            S_AEOI:  state_n = S_IDLE;
            default: state_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            isr        <= '0;
            imr        <= '0;
            top_q      <= '0;
            vbase      <= '0;
            vec_chan   <= '0;
            poll_en    <= 1'b0;
            autorot_en <= 1'b0;
            aeoi_en    <= 1'b0;
        end else if (cmd_init) begin
            isr        <= '0;
            imr        <= '0;
            top_q      <= '0;
            vbase      <= init_vbase;
            poll_en    <= 1'b0;
            autorot_en <= 1'b0;
            aeoi_en    <= init_aeoi;
        end else begin
            isr <= (isr & ~eoi_clr & ~aeoi_clr) | grant_1h;
            if (cmd_mask) imr <= mask_val;
            if (cmd_mode) begin
                poll_en    <= mode_poll;
                autorot_en <= mode_autorot;
            end
            if (take) vec_chan <= elig ? req_chan : CW'(NCH - 1);
            if (cmd_rot)                      top_q <= rot_top;
            else if (autorot_en && eoi_hit)   top_q <= eoi_ch + CW'(1);
            else if (autorot_en && aeoi_hit)  top_q <= isu_chan + CW'(1);
        end
    end

    always_comb begin
        intr      = elig && !poll_en;
        vec_valid = (state == S_GRANT);
        vec       = {vbase, vec_chan};
    end

    // R5
    grant_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_GRANT) |-> $past(ack_pulse));

    // R5
    one_entry_per_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(isr & ~$past(isr)) <= 1));

    // R10
    aeoi_follows_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_AEOI) |-> ($past(state) == S_GRANT));

    // R2
    intr_needs_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        intr |-> ((irr & ~imr) != '0));
endmodule

// File: tb/prio_irq_core_bench.sv
`timescale 1ns/1ps
module prio_irq_core_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = '0;
    logic       ack_pulse = 0, cmd_init = 0, init_aeoi = 0, cmd_mask = 0;
    logic [4:0] init_vbase = '0;
    logic [7:0] mask_val = '0;
    logic       cmd_eoi = 0, eoi_specific = 0, cmd_rot = 0, cmd_mode = 0;
    logic [2:0] eoi_chan = '0, rot_top = '0;
    logic       mode_poll = 0, mode_autorot = 0;
    logic       intr, vec_valid;
    logic [7:0] vec, irr, isr, imr;

    int checks = 0, errors = 0;
    logic [7:0] m_irr = 0, m_isr = 0, m_imr = 0;
    int m_top = 0;
    logic m_poll = 0, m_auto = 0, m_aeoi = 0;
    logic [4:0] m_vbase = 0;

    always #2 clk = ~clk;

    prio_irq_core u_prio_irq_core (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ack_pulse(ack_pulse),
        .cmd_init(cmd_init), .init_vbase(init_vbase), .init_aeoi(init_aeoi),
        .cmd_mask(cmd_mask), .mask_val(mask_val), .cmd_eoi(cmd_eoi),
        .eoi_specific(eoi_specific), .eoi_chan(eoi_chan), .cmd_rot(cmd_rot),
        .rot_top(rot_top), .cmd_mode(cmd_mode), .mode_poll(mode_poll),
        .mode_autorot(mode_autorot), .intr(intr), .vec_valid(vec_valid),
        .vec(vec), .irr(irr), .isr(isr), .imr(imr)
    );

    function automatic int top_of(logic [7:0] b, int t);
        for (int i = 0; i < 8; i++) if (b[(t + i) % 8]) return (t + i) % 8;
        return -1;
    endfunction

    function automatic int rk(int c, int t);
        return (c - t + 8) % 8;
    endfunction

    function automatic int elig_ch();
        int w, s;
        w = top_of(m_irr & ~m_imr, m_top);
        s = top_of(m_isr, m_top);
        if (w < 0) return -1;
        if (s >= 0 && rk(s, m_top) <= rk(w, m_top)) return -1;
        return w;
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_state(string ctx);
        chk({"R1 irr ", ctx}, int'(irr), int'(m_irr));
        chk({"R5 isr ", ctx}, int'(isr), int'(m_isr));
        chk({"R2 imr ", ctx}, int'(imr), int'(m_imr));
        chk({"R3 intr ", ctx}, int'(intr), int'(elig_ch() >= 0 && !m_poll));
    endtask

    task automatic release_ch(int c);
        if (c >= 0 && m_isr[c]) begin
            m_isr[c] = 1'b0;
            if (m_auto) m_top = (c + 1) % 8;   // R8
        end
    endtask

    task automatic pulse_irq(logic [7:0] b);
        irq_in = irq_in | b;
        tick(4);
        irq_in = irq_in & ~b;
        tick(3);
        m_irr = m_irr | b;
    endtask

    task automatic do_ack(string tag);
        int w;
        w = elig_ch();
        ack_pulse = 1'b1;
        tick(1);
        ack_pulse = 1'b0;
        chk({tag, " R5 vec_valid"}, int'(vec_valid), 1);
        chk({tag, " R5/R6 vec"}, int'(vec), int'({m_vbase, 3'(w < 0 ? 7 : w)}));
        if (w >= 0) begin
            m_isr[w] = 1'b1;
            m_irr[w] = 1'b0;
        end
        if (m_aeoi) begin
            tick(2);
            release_ch(top_of(m_isr & ~m_imr, m_top));   // R10
        end else tick(1);
    endtask

    task automatic do_eoi(logic spec, int c);
        cmd_eoi = 1'b1; eoi_specific = spec; eoi_chan = 3'(c);
        tick(1);
        cmd_eoi = 1'b0;
        release_ch(spec ? c : top_of(m_isr & ~m_imr, m_top));   // R9
    endtask

    task automatic do_mask(logic [7:0] v);
        cmd_mask = 1'b1; mask_val = v;
        tick(1);
        cmd_mask = 1'b0;
        m_imr = v;
    endtask

    task automatic do_rot(int t);
        cmd_rot = 1'b1; rot_top = 3'(t);
        tick(1);
        cmd_rot = 1'b0;
        m_top = t;
    endtask

    task automatic do_mode(logic p, logic a);
        cmd_mode = 1'b1; mode_poll = p; mode_autorot = a;
        tick(1);
        cmd_mode = 1'b0;
        m_poll = p; m_auto = a;
    endtask

    task automatic do_init(logic [4:0] b, logic ae);
        cmd_init = 1'b1; init_vbase = b; init_aeoi = ae;
        tick(1);
        cmd_init = 1'b0;
        m_isr = 0; m_imr = 0; m_top = 0; m_poll = 0; m_auto = 0;
        m_vbase = b; m_aeoi = ae;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = 7;
        void'($urandom(seed));
        tick(3);
        rst_n = 1'b1;
        tick(1);
        check_state("after reset");
        chk("R5 vec_valid idle", int'(vec_valid), 0);

        do_init(5'h10, 1'b0);
        // R4: fixed order, 2 beats 5
        pulse_irq(8'b0010_0100);
        check_state("two pending");
        do_ack("R4 fixed");
        // R3: 5 is below in-service 2
        check_state("R3 blocked");
        do_eoi(1'b0, 0);
        check_state("R9 nonspecific");

        // R2 mask, then R6 spurious
        do_mask(8'b0010_0000);
        check_state("R2 masked");
        chk("R2 intr masked", int'(intr), 0);
        do_ack("R6 spurious");
        check_state("R6 after spurious");
        do_mask(8'h00);

        // R7: top 6, pending 1,5,7 -> 7 wins
        do_rot(6);
        pulse_irq(8'b1000_0010);
        do_ack("R7 rotation");
        chk("R7 winner 7", int'(isr), 8'h80);
        do_eoi(1'b1, 7);
        check_state("R9 specific");

        // R8: automatic rotation
        do_mode(1'b0, 1'b1);
        do_ack("R8 first");
        do_eoi(1'b0, 0);
        chk("R8 rotated top", int'(intr), 1);
        pulse_irq(8'b0000_1001);
        do_ack("R8 order");
        chk("R8 winner 3", int'(isr), 8'h08);
        do_eoi(1'b0, 0);
        check_state("R8 after");

        // R11 poll
        do_mode(1'b1, 1'b0);
        check_state("R11 poll");
        chk("R11 intr low", int'(intr), 0);
        do_ack("R11 poll ack");
        check_state("R11 after ack");

        // R13 init after masking
        do_mask(8'hF0);
        do_init(5'h05, 1'b1);
        check_state("R13 init");
        // R10 auto release
        do_ack("R10 aeoi");
        check_state("R10 after");

        // R12: fresh edge lands on the grant edge
        do_init(5'h03, 1'b0);
        while (m_irr != 0) begin
            do_ack("R12 drain");
            do_eoi(1'b0, 0);
        end
        pulse_irq(8'b0000_0100);
        irq_in[2] = 1'b1;
        tick(2);
        ack_pulse = 1'b1;
        tick(1);
        ack_pulse = 1'b0;
        chk("R12 vec", int'(vec), int'({5'h03, 3'd2}));
        chk("R12 isr", int'(isr[2]), 1);
        chk("R12 irr kept", int'(irr[2]), 1);
        irq_in[2] = 1'b0;
        tick(4);
        m_isr = 8'h04;
        m_irr = 8'h04;
        check_state("R12 after");
        do_eoi(1'b1, 2);

        // random traffic
        for (int it = 0; it < 300; it++) begin
            int op;
            op = int'($urandom_range(0, 11));
            case (op)
                0, 1, 2: pulse_irq(8'($urandom_range(0, 255)) & ~irq_in);
                3, 4:    do_ack("rand");
                5, 6:    do_eoi(1'b0, 0);
                7:       do_eoi(1'b1, int'($urandom_range(0, 7)));
                8:       do_mask(($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 255)) : 8'h00);
                9:       do_rot(int'($urandom_range(0, 7)));
                10:      do_mode($urandom_range(0, 5) == 0, 1'($urandom_range(0, 1)));
                default: if ($urandom_range(0, 4) == 0)
                             do_init(5'($urandom_range(0, 31)), 1'($urandom_range(0, 1)));
            endcase
            check_state("random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule